// File: doc/BRIEF.md
# Register Pointer with Auto-Increment Windows

This block keeps the register pointer of a small register file that is reached over a serial bus. The first data byte of a bus write is a control byte. Its five low bits select one of eighteen registers, 00h to 11h. Its three high bits select how the pointer moves. The block raises `access_done_i` after each data byte is read or written, and the pointer then steps according to the selected mode. The register storage sits outside this block and decodes `ptr_o`.

The incrementing modes differ in their wrap window. In the full mode the pointer covers every register. In the brightness mode it covers 02h to 09h. In the group mode it covers 0Ah to 0Bh. In the combined mode it covers 02h to 0Bh. A pointer loaded outside its window first counts up through the register space. It wraps from 11h to 00h and keeps counting until it reaches the window, and it circulates inside the window from then on. `ptr_valid_o` tells the bus front end whether the current pointer names a real register, and the front end uses it to decide whether to acknowledge.

Top module: `reg_ptr_ai`

## Requirements
- R1: When `ctrl_wr_i` is high at a clock edge, `ptr_o` takes `ctrl_byte_i[4:0]` and `ai_o` takes `ctrl_byte_i[7:5]` from the next cycle. If `access_done_i` is high at the same edge, it is ignored.
- R2: After reset, `ptr_o` is 00h, `ai_o` is 000 and `ptr_valid_o` is 1.
- R3: `ai_o` changes only on a control write. Pointer steps never alter it.
- R4: With neither `ctrl_wr_i` nor `access_done_i` high, `ptr_o` holds its value.
- R5: In mode 000, and in the reserved mode codes 001, 010 and 011, an access leaves `ptr_o` unchanged.
- R6: In mode 100, an access adds one to the pointer, and 11h steps to 00h.
- R7: In mode 101, the window is 02h to 09h. An access at 09h steps to 02h.
- R8: In mode 110, the window is 0Ah to 0Bh. An access at 0Bh steps to 0Ah.
- R9: In mode 111, the window is 02h to 0Bh. An access at 0Bh steps to 02h.
- R10: A pointer outside the window of an incrementing mode counts up by one and wraps from 11h to 00h until it reaches the window's upper end. Control byte ECh gives 0Ch, 0Dh, …, 11h, 00h, …, 0Bh, 02h.
- R11: `ptr_valid_o` is 1 exactly when `ptr_o` is 11h or below. Pointers 12h to 1Fh are reserved.
- R12: In an incrementing mode, a reserved pointer (12h to 1Fh) steps by one modulo 32, so 1Fh steps to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Load the control byte this cycle |
| ctrl_byte_i | input | 8 | Control byte: [7:5] mode, [4:0] pointer |
| access_done_i | input | 1 | One data byte was read or written |
| ptr_o | output | 5 | Current register pointer |
| ai_o | output | 3 | Current auto-increment mode |
| ptr_valid_o | output | 1 | Pointer names an existing register |

## Verification
The stepping logic is tested with start points placed just below each window's upper end. This separates a wrap back to the window start from plain counting and from the global 11h-to-00h wrap. The control byte ECh starts outside its window, so it exercises both wraps in one run and shows the window is entered only from below. The tests also hold the pointer in mode 000 and in the reserved modes, and step through reserved pointers up to 1Fh. Together these tell a no-increment decode apart from a free-running counter and check the validity flag at the 11h/12h boundary. A control write that coincides with an access checks the load priority.

// File: rtl/ptr_ai_pkg.sv
package ptr_ai_pkg;
  localparam int PTR_W    = 5;
  localparam int MODE_W   = 3;
  localparam int CTRL_W   = PTR_W + MODE_W;
  localparam int NUM_REGS = 18;
  localparam int BRT_LO   = 2;
  localparam int BRT_HI   = 9;
  localparam int GRP_LO   = 10;
  localparam int GRP_HI   = 11;

  typedef enum logic [MODE_W-1:0] {
    AI_OFF    = 3'b000,
    AI_ALL    = 3'b100,
    AI_BRT    = 3'b101,
    AI_GRP    = 3'b110,
    AI_BRTGRP = 3'b111
  } ai_mode_e;
endpackage

// File: rtl/ai_window_decode.sv
module ai_window_decode
  import ptr_ai_pkg::*;
#(
  parameter int PW   = PTR_W,
  parameter int LAST = NUM_REGS - 1
) (
  input  logic [MODE_W-1:0] mode_i,
  output logic              inc_en_o,
  output logic [PW-1:0]     win_lo_o,
  output logic [PW-1:0]     win_hi_o
);
  localparam logic [PW-1:0] LastP = PW'(LAST);

  always_comb begin
    inc_en_o = 1'b1;
    win_lo_o = '0;
    win_hi_o = LastP;
    case (mode_i)
      AI_ALL: ;
      AI_BRT: begin
        win_lo_o = PW'(BRT_LO);
        win_hi_o = PW'(BRT_HI);
      end
      AI_GRP: begin
        win_lo_o = PW'(GRP_LO);
        win_hi_o = PW'(GRP_HI);
      end
      AI_BRTGRP: begin
        win_lo_o = PW'(BRT_LO);
        win_hi_o = PW'(GRP_HI);
      end
      default: inc_en_o = 1'b0; // 000 and reserved codes hold
    endcase
  end
endmodule

// File: rtl/ptr_step.sv
module ptr_step #(
  parameter int PW   = 5,
  parameter int LAST = 17
) (
  input  logic [PW-1:0] cur_i,
  input  logic          inc_en_i,
  input  logic [PW-1:0] win_lo_i,
  input  logic [PW-1:0] win_hi_i,
  output logic [PW-1:0] nxt_o
);
  localparam logic [PW-1:0] LastP = PW'(LAST);

  always_comb begin
    if (!inc_en_i)                nxt_o = cur_i;
    else if (cur_i == win_hi_i)   nxt_o = win_lo_i;
    else if (cur_i == LastP)      nxt_o = '0;
    else                          nxt_o = cur_i + 1'b1; // reserved range wraps mod 2^PW
  end
endmodule

// File: rtl/reg_ptr_ai.sv
module reg_ptr_ai
  import ptr_ai_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_byte_i,
  input  logic              access_done_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [MODE_W-1:0] ai_o,
  output logic              ptr_valid_o
);
  localparam int LAST = NUM_REGS - 1;

  logic [PTR_W-1:0]  ptr_q, ptr_nxt, win_lo, win_hi;
  logic [MODE_W-1:0] ai_q;
  logic              inc_en;

  ai_window_decode #(.PW(PTR_W), .LAST(LAST)) u_dec (
    .mode_i   (ai_q),
    .inc_en_o (inc_en),
    .win_lo_o (win_lo),
    .win_hi_o (win_hi)
  );

  ptr_step #(.PW(PTR_W), .LAST(LAST)) u_step (
    .cur_i    (ptr_q),
    .inc_en_i (inc_en),
    .win_lo_i (win_lo),
    .win_hi_i (win_hi),
    .nxt_o    (ptr_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      ai_q  <= '0;
    end else if (ctrl_wr_i) begin
      ptr_q <= ctrl_byte_i[PTR_W-1:0];
      ai_q  <= ctrl_byte_i[CTRL_W-1:PTR_W];
    end else if (access_done_i) begin
      ptr_q <= ptr_nxt;
    end
  end

  assign ptr_o       = ptr_q;
  assign ai_o        = ai_q;
  assign ptr_valid_o = (ptr_q <= PTR_W'(LAST));
endmodule

// File: rtl/ptr_ai_checker.sv
module ptr_ai_checker
  import ptr_ai_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_wr_i,
  input logic [CTRL_W-1:0] ctrl_byte_i,
  input logic              access_done_i,
  input logic [PTR_W-1:0]  ptr_o,
  input logic [MODE_W-1:0] ai_o,
  input logic              ptr_valid_o
);
  localparam logic [PTR_W-1:0] LastP = PTR_W'(NUM_REGS - 1);

  a_r1_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> (ptr_o == $past(ctrl_byte_i[PTR_W-1:0])) &&
                  (ai_o == $past(ctrl_byte_i[CTRL_W-1:PTR_W])));

  a_r3_mode_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr_i |=> $stable(ai_o));

  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_wr_i && !access_done_i) |=> $stable(ptr_o));

  a_r5_no_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_wr_i && access_done_i && !ai_o[2]) |=> $stable(ptr_o));

  a_r6_full_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_wr_i && access_done_i && ai_o == 3'b100 && ptr_o == LastP) |=> ptr_o == '0);

  a_r7_brt_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_wr_i && access_done_i && ai_o == 3'b101 && ptr_o == 5'h09) |=> ptr_o == 5'h02);

  a_r8_grp_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_wr_i && access_done_i && ai_o == 3'b110 && ptr_o == 5'h0B) |=> ptr_o == 5'h0A);

  a_r9_both_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_wr_i && access_done_i && ai_o == 3'b111 && ptr_o == 5'h0B) |=> ptr_o == 5'h02);

  always_comb begin
    if (rst_ni) begin
      a_r11_valid: assert (ptr_valid_o == (ptr_o <= LastP));
    end
  end
endmodule

bind reg_ptr_ai ptr_ai_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ctrl_wr_i     (ctrl_wr_i),
  .ctrl_byte_i   (ctrl_byte_i),
  .access_done_i (access_done_i),
  .ptr_o         (ptr_o),
  .ai_o          (ai_o),
  .ptr_valid_o   (ptr_valid_o)
);

// File: tb/tb_reg_ptr_ai.sv
module tb_reg_ptr_ai;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_byte = '0;
  logic       access_done = 1'b0;
  logic [4:0] ptr;
  logic [2:0] ai;
  logic       ptr_valid;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_ptr_ai dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .ctrl_wr_i     (ctrl_wr),
    .ctrl_byte_i   (ctrl_byte),
    .access_done_i (access_done),
    .ptr_o         (ptr),
    .ai_o          (ai),
    .ptr_valid_o   (ptr_valid)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // one cycle: drive at negedge, sample at following negedge
  task automatic cyc(input logic wr, input logic [7:0] b, input logic done);
    ctrl_wr = wr; ctrl_byte = b; access_done = done;
    @(negedge clk);
    ctrl_wr = 1'b0; access_done = 1'b0;
  endtask

  task automatic load(input logic [7:0] b);
    cyc(1'b1, b, 1'b0);
  endtask

  task automatic acc();
    cyc(1'b0, 8'h00, 1'b1);
  endtask

  task automatic t_reset();
    check("R2 ptr", ptr, 0);
    check("R2 ai", ai, 0);
    check("R2 valid", ptr_valid, 1);
  endtask

  task automatic t_load();
    load(8'hA5);
    check("R1 ptr", ptr, 5'h05);
    check("R1 ai", ai, 3'b101);
    cyc(1'b1, 8'h83, 1'b1); // access ignored on load
    check("R1 priority", ptr, 5'h03);
    cyc(1'b0, 8'h00, 1'b0);
    cyc(1'b0, 8'h00, 1'b0);
    check("R4 idle", ptr, 5'h03);
  endtask

  task automatic t_hold_modes();
    for (int m = 0; m < 4; m++) begin
      load({m[2:0], 5'h07});
      acc(); acc(); acc();
      check("R5 hold", ptr, 5'h07);
      check("R3 mode", ai, m);
    end
  endtask

  task automatic t_full();
    load(8'h90);
    acc(); check("R6 step", ptr, 5'h11);
    acc(); check("R6 wrap", ptr, 5'h00);
    acc(); check("R6 after", ptr, 5'h01);
    check("R3 mode", ai, 3'b100);
  endtask

  task automatic t_brt();
    load(8'hA8);
    acc(); check("R7 step", ptr, 5'h09);
    acc(); check("R7 wrap", ptr, 5'h02);
    acc(); check("R7 after", ptr, 5'h03);
  endtask

  task automatic t_grp();
    load(8'hCA);
    acc(); check("R8 step", ptr, 5'h0B);
    acc(); check("R8 wrap", ptr, 5'h0A);
    acc(); check("R8 again", ptr, 5'h0B);
  endtask

  task automatic t_both();
    load(8'hEB);
    acc(); check("R9 wrap", ptr, 5'h02);
  endtask

  task automatic t_outside();
    load(8'hEC);
    for (int i = 0; i < 6; i++) acc();
    check("R10 global wrap", ptr, 5'h00);
    for (int i = 0; i < 11; i++) acc();
    check("R10 reach hi", ptr, 5'h0B);
    acc(); check("R10 enter window", ptr, 5'h02);
    check("R3 mode", ai, 3'b111);
  endtask

  task automatic t_valid();
    load(8'h11); check("R11 11h", ptr_valid, 1);
    load(8'h12); check("R11 12h", ptr_valid, 0);
    load(8'h9E);
    acc(); check("R12 step", ptr, 5'h1F);
    check("R11 1Fh", ptr_valid, 0);
    acc(); check("R12 wrap", ptr, 5'h00);
    check("R11 00h", ptr_valid, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_hold_modes();
    t_full();
    t_brt();
    t_grp();
    t_both();
    t_outside();
    t_valid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule